// File: doc/BRIEF.md
# Flash Write Unlock Controller

This block gates every programming operation on nonvolatile program memory behind a software key. The CPU reaches it through a small register bus with four byte-wide locations: a control/status byte, a key port, a completion flag byte and an interrupt enable byte. A programming operation is launched only when the first key byte and then the second key byte are written to the key port, and the very next bus access is a control write that sets the start bit while write permission is already on. Any other pattern falls back to the idle state and nothing is launched.

Once launched, the block raises a request toward an abstract memory-programming port and holds the CPU stalled until that port answers with a one-cycle done. Completion clears the start bit, releases the stall and sets a sticky flag that can drive an interrupt. Two reset inputs separate a power-on reset from any other reset, such as an external pin or a watchdog. A non-power-on reset that lands during a write cuts the request at once and leaves a readable error bit. The memory-select bits survive that kind of reset.

The clock must keep running while either reset is held low, because the error bit is captured on a clock edge during reset.

Top module: `flash_unlock_ctrl`

## Requirements
- R1: After power-on reset the control byte reads 00h, the flag and enable bytes read 00h, and `stall`, `prog_req`, `rd_req` and `done_irq` are low.
- R2: The first key byte 55h and the second key byte AAh must be written to the key port (address 1), in that order, and they must be immediately followed by a control write with bit 1 set. Any other order, or any other bus access in between (reads included), must not launch a write.
- R3: The control byte sits at address 0. A launching control write makes `prog_req` and `stall` high from the clock edge that takes the write, and control bit 1 then reads 1.
- R4: When `prog_done` is high while a write is in progress, `prog_req` and `stall` drop after that edge, control bit 1 reads 0, and completion flag bit 0 (address 2) becomes 1.
- R5: The start bit launches nothing unless write permission (control bit 2) was already 1 before the start write.
- R6: Reads of the key port return 00h. Writes to the key port change no readable register.
- R7: Writing 1 to control bit 0 raises `rd_req` for exactly one cycle. The bit then reads 0 again.
- R8: While a write is in progress, bus writes are ignored and the control byte keeps its value.
- R9: A low pulse on `rst_n` during a write drops `prog_req` without waiting for a clock edge. Afterwards control bit 3 (error) reads 1, bits 7 and 6 keep their values, and bits 4, 2, 1 and 0 read 0.
- R10: While a write is in progress, `prog_erase` follows control bit 4 and `prog_space` follows control bits 7:6.
- R11: The error bit is cleared by a control write with bit 3 at 0. A control write with bit 3 at 1 never sets it.
- R12: `done_irq` is completion flag bit 0 ANDed with enable bit 0 (address 3). Writing 1 to flag bit 0 clears the flag.
- R13: Power-on reset clears control bits 7, 6 and 3, even when another reset has left them set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Any other reset (external or watchdog), active low, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 control, 1 key, 2 flag, 3 enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| stall | output | 1 | Holds the CPU while a write is in progress |
| prog_req | output | 1 | Programming request to the memory port |
| prog_erase | output | 1 | Row erase requested with the write |
| prog_space | output | 2 | Selected memory space {memory select, config select} |
| prog_done | input | 1 | One-cycle completion from the memory port |
| rd_req | output | 1 | One-cycle read request |
| done_irq | output | 1 | Completion interrupt |

## Verification
The bench targets key sequences that come close to the correct one but are wrong. It sends the keys in reverse order, a single key, a flag read between the two keys, and a correct sequence while write permission is off. A block whose state machine ignored reads or checked only the last key would start programming in one of these cases. A reset that arrives in the middle of a write is checked at the request pin before any clock edge, and the error and select bits are read back afterwards. A design that waited for a clock, or cleared the persistent bits, is caught there. Bus writes during the stall, the error bit's clear-only write rule, and a power-on reset that follows an aborted write are each checked against the readable control byte.

// File: rtl/flash_unlock_pkg.sv
package flash_unlock_pkg;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_KEY1  = 2'd1,
    UL_ARMED = 2'd2
  } ul_state_e;

  localparam int BYTE_W    = 8;
  localparam int B_RD      = 0;
  localparam int B_WR      = 1;
  localparam int B_WREN    = 2;
  localparam int B_ERR     = 3;
  localparam int B_ERASE   = 4;
  localparam int B_CFG     = 6;
  localparam int B_MEM     = 7;

endpackage

// File: rtl/fu_unlock.sv
module fu_unlock
  import flash_unlock_pkg::*;
#(
  parameter logic [7:0] KEY_FIRST  = 8'h55,
  parameter logic [7:0] KEY_SECOND = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       start_try,
  input  logic       wren,
  output logic       launch
);

  ul_state_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    launch = 1'b0;
    if (acc) begin
      if (key_wr) begin
        if (key_data == KEY_FIRST)                          st_d = UL_KEY1;
        else if (key_data == KEY_SECOND && st_q == UL_KEY1) st_d = UL_ARMED;
        else                                                st_d = UL_IDLE;
      end else begin
        launch = start_try && wren && (st_q == UL_ARMED);
        st_d   = UL_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UL_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/fu_prog_seq.sv
module fu_prog_seq (
  input  logic clk,
  input  logic ctl_rst_n,
  input  logic por_n,
  input  logic rst_n,
  input  logic launch,
  input  logic prog_done,
  input  logic err_clr,
  output logic busy,
  output logic done_pulse,
  output logic err
);

  logic busy_d, live_q, live_d, err_d;

  assign done_pulse = busy && prog_done;

  always_comb begin
    busy_d = busy;
    if (launch)          busy_d = 1'b1;
    else if (done_pulse) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) busy <= 1'b0;
    else            busy <= busy_d;
  end

  always_comb begin
    live_d = live_q;
    err_d  = err;
    if (!rst_n) begin
      live_d = 1'b0;
      if (live_q) err_d = 1'b1;
    end else begin
      if (launch)          live_d = 1'b1;
      else if (done_pulse) live_d = 1'b0;
      if (err_clr)         err_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      live_q <= 1'b0;
      err    <= 1'b0;
    end else begin
      live_q <= live_d;
      err    <= err_d;
    end
  end

endmodule

// File: rtl/fu_irq.sv
module fu_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic done_pulse,
  input  logic flag_clr,
  input  logic en_we,
  input  logic en_bit,
  output logic flag,
  output logic en,
  output logic irq
);

  logic flag_d, en_d;

  always_comb begin
    flag_d = flag;
    en_d   = en;
    if (done_pulse)    flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    if (en_we)         en_d   = en_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      en   <= 1'b0;
    end else begin
      flag <= flag_d;
      en   <= en_d;
    end
  end

  assign irq = flag && en;

endmodule

// File: rtl/flash_unlock_ctrl.sv
module flash_unlock_ctrl
  import flash_unlock_pkg::*;
#(
  parameter logic [7:0] KEY_FIRST  = 8'h55,
  parameter logic [7:0] KEY_SECOND = 8'hAA,
  parameter int         AW         = 2,
  parameter int         ADDR_CSR   = 0,
  parameter int         ADDR_KEY   = 1,
  parameter int         ADDR_FLAG  = 2,
  parameter int         ADDR_IEN   = 3
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          stall,
  output logic          prog_req,
  output logic          prog_erase,
  output logic [1:0]    prog_space,
  input  logic          prog_done,
  output logic          rd_req,
  output logic          done_irq
);

  localparam logic [AW-1:0] A_CSR  = AW'(ADDR_CSR);
  localparam logic [AW-1:0] A_KEY  = AW'(ADDR_KEY);
  localparam logic [AW-1:0] A_FLAG = AW'(ADDR_FLAG);
  localparam logic [AW-1:0] A_IEN  = AW'(ADDR_IEN);

  logic ctl_rst_n, busy, acc, wr, csr_wr, key_wr, start_try, launch;
  logic done_pulse, err, flag, en, err_clr;
  logic mem_q, mem_d, cfg_q, cfg_d;
  logic erase_q, erase_d, wren_q, wren_d, rd_q, rd_d;
  logic unused_bit5;

  assign ctl_rst_n   = rst_n && por_n;
  assign acc         = bus_sel && !busy && rst_n;
  assign wr          = acc && bus_we;
  assign csr_wr      = wr && (bus_addr == A_CSR);
  assign key_wr      = wr && (bus_addr == A_KEY);
  assign start_try   = csr_wr && bus_wdata[B_WR];
  assign err_clr     = csr_wr && !bus_wdata[B_ERR];
  assign unused_bit5 = bus_wdata[5];

  fu_unlock #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_unlock (
    .clk(clk), .rst_n(ctl_rst_n), .acc(acc), .key_wr(key_wr),
    .key_data(bus_wdata), .start_try(start_try), .wren(wren_q), .launch(launch)
  );

  fu_prog_seq u_seq (
    .clk(clk), .ctl_rst_n(ctl_rst_n), .por_n(por_n), .rst_n(rst_n),
    .launch(launch), .prog_done(prog_done), .err_clr(err_clr),
    .busy(busy), .done_pulse(done_pulse), .err(err)
  );

  fu_irq u_irq (
    .clk(clk), .rst_n(ctl_rst_n), .done_pulse(done_pulse),
    .flag_clr(wr && (bus_addr == A_FLAG) && bus_wdata[0]),
    .en_we(wr && (bus_addr == A_IEN)), .en_bit(bus_wdata[0]),
    .flag(flag), .en(en), .irq(done_irq)
  );

  always_comb begin
    mem_d   = mem_q;
    cfg_d   = cfg_q;
    erase_d = erase_q;
    wren_d  = wren_q;
    rd_d    = csr_wr && bus_wdata[B_RD];
    if (csr_wr) begin
      mem_d   = bus_wdata[B_MEM];
      cfg_d   = bus_wdata[B_CFG];
      erase_d = bus_wdata[B_ERASE];
      wren_d  = bus_wdata[B_WREN];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mem_q <= 1'b0;
      cfg_q <= 1'b0;
    end else begin
      mem_q <= mem_d;
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) begin
      erase_q <= 1'b0;
      wren_q  <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      erase_q <= erase_d;
      wren_q  <= wren_d;
      rd_q    <= rd_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CSR:   bus_rdata = {mem_q, cfg_q, 1'b0, erase_q, err, wren_q, busy, rd_q};
      A_FLAG:  bus_rdata = {7'd0, flag};
      A_IEN:   bus_rdata = {7'd0, en};
      default: bus_rdata = '0;
    endcase
  end

  assign stall      = busy;
  assign prog_req   = busy;
  assign prog_erase = erase_q;
  assign prog_space = {mem_q, cfg_q};
  assign rd_req     = rd_q;

endmodule

// File: rtl/fu_checker.sv
module fu_checker #(
  parameter int AW = 2
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic          prog_req,
  input logic          prog_done,
  input logic          rd_req,
  input logic          wren_q
);

  assert_launch_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(prog_req) |-> $past(bus_sel && bus_we && bus_addr == AW'(0) && bus_wdata[1]));

  assert_done_ends_req_R4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (prog_req && prog_done) |=> !prog_req);

  assert_needs_wren_R5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(prog_req) |-> $past(wren_q));

  assert_key_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_sel && !bus_we && bus_addr == AW'(1)) |-> (bus_rdata == 8'h00));

  assert_rd_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rd_req |=> !rd_req);

  assert_busy_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    prog_req |=> $stable(wren_q));

endmodule

bind flash_unlock_ctrl fu_checker #(.AW(AW)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .prog_req(prog_req), .prog_done(prog_done), .rd_req(rd_req), .wren_q(wren_q)
);

// File: tb/flash_unlock_ctrl_test.sv
`timescale 1ns/1ps
module flash_unlock_ctrl_test;

  logic       clk = 1'b0;
  logic       por_n, rst_n, bus_sel, bus_we, prog_done;
  logic [1:0] bus_addr, prog_space;
  logic [7:0] bus_wdata, bus_rdata;
  logic       stall, prog_req, prog_erase, rd_req, done_irq;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  flash_unlock_ctrl uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stall(stall), .prog_req(prog_req), .prog_erase(prog_erase),
    .prog_space(prog_space), .prog_done(prog_done), .rd_req(rd_req),
    .done_irq(done_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); prog_done = 1'b1;
    @(posedge clk); #1 prog_done = 1'b0;
  endtask

  task automatic do_reset(input logic por);
    @(negedge clk);
    rst_n = 1'b0; if (por) por_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset(1'b1);
    rd(2'd0, v); check("R1 csr", v, 8'h00);
    rd(2'd2, v); check("R1 flag", v, 8'h00);
    rd(2'd3, v); check("R1 enable", v, 8'h00);
    check("R1 outputs", {4'd0, stall, prog_req, rd_req, done_irq}, 8'h00);
  endtask

  task automatic t_good_write();
    logic [7:0] v;
    wr(2'd0, 8'h94);
    wr(2'd1, 8'h55); wr(2'd1, 8'hAA); wr(2'd0, 8'h96);
    @(negedge clk);
    check("R3 req/stall", {6'd0, prog_req, stall}, 8'h03);
    check("R10 erase/space", {5'd0, prog_erase, prog_space}, 8'h06);
    rd(2'd0, v); check("R3 start bit", v, 8'h96);
    repeat (3) @(posedge clk);
    @(negedge clk); check("R3 still busy", {7'd0, prog_req}, 8'h01);
    done_pulse();
    @(negedge clk);
    check("R4 req/stall low", {6'd0, prog_req, stall}, 8'h00);
    rd(2'd0, v); check("R4 start bit clear", v, 8'h94);
    rd(2'd2, v); check("R4 flag", v, 8'h01);
    wr(2'd2, 8'h01);
  endtask

  task automatic t_bad_sequences();
    wr(2'd0, 8'h04);
    wr(2'd1, 8'hAA); wr(2'd1, 8'h55); wr(2'd0, 8'h06);
    @(negedge clk); check("R2 reversed keys", {7'd0, prog_req}, 8'h00);
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h55); wr(2'd0, 8'h06);
    @(negedge clk); check("R2 single key", {7'd0, prog_req}, 8'h00);
    begin
      logic [7:0] v;
      wr(2'd0, 8'h04);
      wr(2'd1, 8'h55); rd(2'd2, v); wr(2'd1, 8'hAA); wr(2'd0, 8'h06);
    end
    @(negedge clk); check("R2 read between keys", {7'd0, prog_req}, 8'h00);
  endtask

  task automatic t_wren_off();
    logic [7:0] v;
    wr(2'd0, 8'h80);
    wr(2'd1, 8'h55); wr(2'd1, 8'hAA); wr(2'd0, 8'h86);
    @(negedge clk); check("R5 no launch", {7'd0, prog_req}, 8'h00);
    rd(2'd0, v); check("R5 start bit", v, 8'h84);
  endtask

  task automatic t_key_port();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h3C);
    rd(2'd1, v); check("R6 key reads zero", v, 8'h00);
    rd(2'd0, v); check("R6 csr untouched", v, 8'h00);
  endtask

  task automatic t_read_pulse();
    logic [7:0] v;
    wr(2'd0, 8'h01);
    @(negedge clk); check("R7 pulse", {7'd0, rd_req}, 8'h01);
    @(negedge clk); check("R7 pulse ends", {7'd0, rd_req}, 8'h00);
    rd(2'd0, v); check("R7 bit clear", v, 8'h00);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h55); wr(2'd1, 8'hAA); wr(2'd0, 8'h06);
    wr(2'd0, 8'h00);
    rd(2'd0, v); check("R8 csr frozen", v, 8'h06);
    done_pulse();
    wr(2'd2, 8'h01);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    wr(2'd0, 8'hD4);
    wr(2'd1, 8'h55); wr(2'd1, 8'hAA); wr(2'd0, 8'hD6);
    @(negedge clk); rst_n = 1'b0;
    #1 check("R9 async drop", {7'd0, prog_req}, 8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    rd(2'd0, v); check("R9 csr after abort", v, 8'hC8);
  endtask

  task automatic t_err_rules();
    logic [7:0] v;
    wr(2'd0, 8'hC8);
    rd(2'd0, v); check("R11 write 1 keeps err", v, 8'hC8);
    wr(2'd0, 8'hC0);
    rd(2'd0, v); check("R11 clear", v, 8'hC0);
    wr(2'd0, 8'h08);
    rd(2'd0, v); check("R11 write 1 no set", v, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h55); wr(2'd1, 8'hAA); wr(2'd0, 8'h06);
    done_pulse();
    @(negedge clk); check("R12 irq set", {7'd0, done_irq}, 8'h01);
    wr(2'd2, 8'h01);
    @(negedge clk); check("R12 irq cleared", {7'd0, done_irq}, 8'h00);
    rd(2'd2, v); check("R12 flag cleared", v, 8'h00);
  endtask

  task automatic t_por_clears();
    logic [7:0] v;
    wr(2'd0, 8'hC4);
    wr(2'd1, 8'h55); wr(2'd1, 8'hAA); wr(2'd0, 8'hC6);
    do_reset(1'b0);
    rd(2'd0, v); check("R13 pre-check err set", v, 8'hC8);
    do_reset(1'b1);
    rd(2'd0, v); check("R13 por clears", v, 8'h00);
  endtask

  initial begin
    por_n = 1'b0; rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; prog_done = 1'b0;
    t_reset();
    t_good_write();
    t_bad_sequences();
    t_wren_off();
    t_key_port();
    t_read_pulse();
    t_busy_ignore();
    t_abort();
    t_err_rules();
    t_irq();
    t_por_clears();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule